// File: doc/BRIEF.md
# Descriptor-Driven Memory Copy Engine

This block services one channel of a multi-channel DMA controller once an arbiter elsewhere has picked it. A start pulse names the channel. The engine fetches that channel's eight-word descriptor from a word-wide descriptor store and validates it. It then copies the descriptor's minor-loop byte count from the source address to the destination address over a single-outstanding request/acknowledge memory bus. Source and destination may use different access sizes of 1, 2 or 4 bytes, and a small byte-packing stage between the read and write sides converts between them.

After each minor loop the advanced source address, the advanced destination address and the decremented iteration count go back into the descriptor store. The next service therefore continues where the last one stopped. When the iteration count runs out it is reloaded from the starting count, a done flag is written into the descriptor, and completion is signalled. A configuration error stops the service before any bus traffic. A bus error aborts it at once. In both cases an error flag is written into the descriptor and an error interrupt can be raised. Requests for chaining to another channel, or for loading a new descriptor, are only reported on outputs, for surrounding logic to act on.

Descriptor word layout, by word index within the channel's 8-word slot at word address `ch*8`:
- 0: source address
- 1: destination address
- 2: minor-loop byte count
- 3: source offset in bits [31:16] and destination offset in bits [15:0], both signed
- 4: source size code in bits [1:0] and destination size code in bits [3:2]
- 5: starting count in bits [31:16] and current count in bits [15:0]
- 6: control and status word
- 7: reserved

Top module: `dxe_engine`

## Requirements
- R1: On an accepted start the engine reads all 8 words of the channel's slot, at word addresses ch*8 to ch*8+7, before it raises any memory request. The store returns read data one clock after `desc_rd`.
- R2: These are configuration errors: a size code of 3; a byte count that is zero or not a multiple of the larger access size; a source or destination address not aligned to its own access size; a current or starting count of zero. On any of them the engine makes no memory request, writes word 6 back with bit 3 set and the other bits unchanged, and ends with `end_cfg_err`. `irq_err` pulses if word 6 bit 1 is set.
- R3: A service moves exactly the byte count. It makes count/source-size reads and count/destination-size writes, and stream bytes keep their order. Bus data is right-justified and bytes are packed little-endian. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. A 16-byte loop from 1-byte reads to 4-byte writes takes 16 reads and 4 writes.
- R4: The source address advances by the signed source offset after every read. The destination address advances by the signed destination offset after every write.
- R5: After a good minor loop, words 0, 1 and 5 are written back with the advanced addresses and the updated count.
- R6: When the current count was 1, it is reloaded from the starting count. Word 6 is written with bit 2 (done) set and bit 3 clear, `end_major` is set, and `irq_done` pulses if bit 0 is set. Otherwise the count drops by one and bits 2 and 3 are written clear.
- R7: An error response on the bus ends the service with no further requests. Only word 6 is written, with bit 3 set. `end_bus_err` is set, and `irq_err` pulses if bit 1 is set.
- R8: A start pulse while `busy` is high is ignored.
- R9: At the end of a good minor loop, `link_req` pulses if bit 4 is set, with `link_ch` taken from bits [15:8]. `sg_req` pulses on major completion if bit 5 is set.
- R10: A memory request keeps its address, direction and size until acknowledged or errored.
- R11: After reset, `busy`, `mem_req`, `desc_rd`, `desc_we` and every end flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a service of `start_ch` |
| start_ch | input | CH_W | Granted channel |
| desc_rd | output | 1 | Descriptor store read strobe |
| desc_we | output | 1 | Descriptor store write strobe |
| desc_addr | output | CH_W+3 | Descriptor store word address |
| desc_wdata | output | 32 | Descriptor write data |
| desc_rdata | input | 32 | Descriptor read data, one clock after `desc_rd` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Right-justified write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed |
| mem_rdata | input | 32 | Right-justified read data, valid with `mem_ack` |
| busy | output | 1 | Service in progress |
| end_pulse | output | 1 | One-cycle pulse at service end |
| end_major | output | 1 | Last service completed the major loop |
| end_cfg_err | output | 1 | Last service stopped on a configuration error |
| end_bus_err | output | 1 | Last service aborted on a bus error |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |
| link_req | output | 1 | Channel-chain request pulse |
| link_ch | output | CH_W | Channel to chain to |
| sg_req | output | 1 | New-descriptor request pulse |

## Verification
Random services cover every pairing of source and destination sizes with forward, backward and doubled strides. Each is compared with a byte-stream model of the whole memory image. Narrow-to-wide, wide-to-narrow and equal-width runs each exercise a different branch of the packing stage. Negative strides separate a correct sign extension of the offsets from a zero extension. A two-step major loop separates a reload from a plain decrement. The four bad descriptors, a mid-loop bus fault and a start during a busy service each show whether the engine stops before or after touching memory.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

  localparam int DW = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_CHECK,
    S_XFER,
    S_WAIT,
    S_WB,
    S_FIN
  } dxe_state_t;

  localparam int CTL_IRQ_MAJ = 0;
  localparam int CTL_IRQ_ERR = 1;
  localparam int CTL_DONE    = 2;
  localparam int CTL_ERR     = 3;
  localparam int CTL_LINK    = 4;
  localparam int CTL_SG      = 5;
  localparam int CTL_LCH_LSB = 8;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [DW-1:0] byte_mask(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/dxe_cfg_check.sv
module dxe_cfg_check
  import dxe_pkg::*;
#(
  parameter int IT_W = 16
) (
  input  logic [31:0]     saddr,
  input  logic [31:0]     daddr,
  input  logic [31:0]     nbytes,
  input  logic [1:0]      ssz,
  input  logic [1:0]      dsz,
  input  logic [IT_W-1:0] citer,
  input  logic [IT_W-1:0] biter,
  output logic            cfg_err
);
  logic [2:0]  sb, db, big;
  logic [31:0] smask, dmask, bmask;

  always_comb begin
    sb    = size_bytes(ssz);
    db    = size_bytes(dsz);
    big   = (sb > db) ? sb : db;
    smask = {29'd0, sb - 3'd1};
    dmask = {29'd0, db - 3'd1};
    bmask = {29'd0, big - 3'd1};
    cfg_err = (ssz == 2'd3) || (dsz == 2'd3) ||
              (nbytes == 32'd0) ||
              ((nbytes & bmask) != 32'd0) ||
              ((saddr & smask) != 32'd0) ||
              ((daddr & dmask) != 32'd0) ||
              (citer == '0) || (biter == '0);
  end
endmodule

// File: rtl/dxe_pack.sv
module dxe_pack
  import dxe_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic [2:0]    push_bytes,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [2:0]    pop_bytes,
  output logic [2:0]    level,
  output logic [DW-1:0] head
);
  logic [DW-1:0] stage_q;
  logic [2:0]    level_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      stage_q <= '0;
      level_q <= '0;
    end else if (push) begin
      stage_q <= stage_q | ((push_data & byte_mask(push_bytes)) << {level_q, 3'b000});
      level_q <= level_q + push_bytes;
    end else if (pop) begin
      stage_q <= stage_q >> {pop_bytes, 3'b000};
      level_q <= level_q - pop_bytes;
    end
  end

  assign level = level_q;
  assign head  = stage_q;

  AST_PACK_ROOM: assert property (@(posedge clk) disable iff (rst)
    push |-> ({1'b0, level_q} + {1'b0, push_bytes} <= 4'd4)); // R3
  AST_PACK_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    pop |-> (level_q >= pop_bytes)); // R3
endmodule

// File: rtl/dxe_engine.sv
module dxe_engine
  import dxe_pkg::*;
#(
  parameter int CH_NUM = 16,
  parameter int IT_W   = 16,
  localparam int CH_W  = (CH_NUM > 1) ? $clog2(CH_NUM) : 1,
  localparam int DA_W  = CH_W + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CH_W-1:0] start_ch,
  output logic            desc_rd,
  output logic            desc_we,
  output logic [DA_W-1:0] desc_addr,
  output logic [31:0]     desc_wdata,
  input  logic [31:0]     desc_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [1:0]      mem_size,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [31:0]     mem_rdata,
  output logic            busy,
  output logic            end_pulse,
  output logic            end_major,
  output logic            end_cfg_err,
  output logic            end_bus_err,
  output logic            irq_done,
  output logic            irq_err,
  output logic            link_req,
  output logic [CH_W-1:0] link_ch,
  output logic            sg_req
);
  dxe_state_t state;

  logic [CH_W-1:0] ch_q;
  logic [31:0]     saddr, daddr, nbytes, rem, ctl;
  logic [15:0]     soff, doff;
  logic [1:0]      ssz, dsz;
  logic [IT_W-1:0] citer, biter;
  logic            rvalid_q;
  logic [2:0]      ridx_q;
  logic [1:0]      wb_idx;
  logic            major_q, cerr_q, berr_q;

  logic            cfg_err;
  logic [2:0]      sb, db, level;
  logic [31:0]     head;
  logic            push, pop, pclear;
  logic [31:0]     soff_x, doff_x;
  logic [2:0]      wb_word;
  logic [31:0]     wb_val;

  assign sb     = size_bytes(ssz);
  assign db     = size_bytes(dsz);
  assign soff_x = {{16{soff[15]}}, soff};
  assign doff_x = {{16{doff[15]}}, doff};
  assign push   = (state == S_WAIT) && mem_ack && !mem_err && !mem_we;
  assign pop    = (state == S_WAIT) && mem_ack && !mem_err && mem_we;
  assign pclear = (state == S_CHECK);

  dxe_cfg_check #(.IT_W(IT_W)) u_chk (
    .saddr(saddr), .daddr(daddr), .nbytes(nbytes), .ssz(ssz), .dsz(dsz),
    .citer(citer), .biter(biter), .cfg_err(cfg_err)
  );

  dxe_pack u_pack (
    .clk(clk), .rst(rst), .clear(pclear),
    .push(push), .push_bytes(sb), .push_data(mem_rdata),
    .pop(pop), .pop_bytes(db),
    .level(level), .head(head)
  );

  always_comb begin
    case (wb_idx)
      2'd0:    begin wb_word = 3'd0; wb_val = saddr; end
      2'd1:    begin wb_word = 3'd1; wb_val = daddr; end
      2'd2:    begin wb_word = 3'd5; wb_val = {16'(biter), 16'(citer)}; end
      default: begin wb_word = 3'd6; wb_val = ctl; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ch_q        <= '0;
      saddr       <= '0;
      daddr       <= '0;
      nbytes      <= '0;
      rem         <= '0;
      ctl         <= '0;
      soff        <= '0;
      doff        <= '0;
      ssz         <= '0;
      dsz         <= '0;
      citer       <= '0;
      biter       <= '0;
      rvalid_q    <= 1'b0;
      ridx_q      <= '0;
      wb_idx      <= '0;
      major_q     <= 1'b0;
      cerr_q      <= 1'b0;
      berr_q      <= 1'b0;
      desc_rd     <= 1'b0;
      desc_we     <= 1'b0;
      desc_addr   <= '0;
      desc_wdata  <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_size    <= '0;
      mem_wdata   <= '0;
      busy        <= 1'b0;
      end_pulse   <= 1'b0;
      end_major   <= 1'b0;
      end_cfg_err <= 1'b0;
      end_bus_err <= 1'b0;
      irq_done    <= 1'b0;
      irq_err     <= 1'b0;
      link_req    <= 1'b0;
      link_ch     <= '0;
      sg_req      <= 1'b0;
    end else begin
      end_pulse <= 1'b0;
      irq_done  <= 1'b0;
      irq_err   <= 1'b0;
      link_req  <= 1'b0;
      sg_req    <= 1'b0;
      rvalid_q  <= desc_rd;
      ridx_q    <= desc_addr[2:0];

      case (state)
        S_IDLE: begin
          if (start) begin
            ch_q        <= start_ch;
            desc_rd     <= 1'b1;
            desc_addr   <= {start_ch, 3'd0};
            busy        <= 1'b1;
            major_q     <= 1'b0;
            cerr_q      <= 1'b0;
            berr_q      <= 1'b0;
            end_major   <= 1'b0;
            end_cfg_err <= 1'b0;
            end_bus_err <= 1'b0;
            state       <= S_LOAD;
          end
        end

        S_LOAD: begin
          if (desc_rd) begin
            if (desc_addr[2:0] == 3'd7) desc_rd <= 1'b0;
            else desc_addr <= desc_addr + 1'b1;
          end
          if (rvalid_q) begin
            case (ridx_q)
              3'd0: saddr  <= desc_rdata;
              3'd1: daddr  <= desc_rdata;
              3'd2: nbytes <= desc_rdata;
              3'd3: begin soff <= desc_rdata[31:16]; doff <= desc_rdata[15:0]; end
              3'd4: begin ssz <= desc_rdata[1:0]; dsz <= desc_rdata[3:2]; end
              3'd5: begin biter <= desc_rdata[16 +: IT_W]; citer <= desc_rdata[IT_W-1:0]; end
              3'd6: ctl <= desc_rdata;
              default: state <= S_CHECK;
            endcase
          end
        end

        S_CHECK: begin
          rem <= nbytes;
          if (cfg_err) begin
            cerr_q       <= 1'b1;
            ctl[CTL_ERR] <= 1'b1;
            wb_idx       <= 2'd3;
            state        <= S_WB;
          end else begin
            state <= S_XFER;
          end
        end

        S_XFER: begin
          if (rem == 32'd0) begin
            major_q       <= (citer == IT_W'(1));
            ctl[CTL_DONE] <= (citer == IT_W'(1));
            ctl[CTL_ERR]  <= 1'b0;
            citer         <= (citer == IT_W'(1)) ? biter : citer - 1'b1;
            wb_idx        <= 2'd0;
            state         <= S_WB;
          end else if (level >= db) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= daddr;
            mem_size  <= dsz;
            mem_wdata <= head & byte_mask(db);
            state     <= S_WAIT;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= saddr;
            mem_size <= ssz;
            state    <= S_WAIT;
          end
        end

        S_WAIT: begin
          if (mem_err) begin
            mem_req      <= 1'b0;
            berr_q       <= 1'b1;
            ctl[CTL_ERR] <= 1'b1;
            wb_idx       <= 2'd3;
            state        <= S_WB;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (mem_we) begin
              daddr <= daddr + doff_x;
              rem   <= rem - {29'd0, db};
            end else begin
              saddr <= saddr + soff_x;
            end
            state <= S_XFER;
          end
        end

        S_WB: begin
          desc_we    <= 1'b1;
          desc_addr  <= {ch_q, wb_word};
          desc_wdata <= wb_val;
          wb_idx     <= wb_idx + 1'b1;
          if (wb_idx == 2'd3) state <= S_FIN;
        end

        S_FIN: begin
          desc_we     <= 1'b0;
          busy        <= 1'b0;
          end_pulse   <= 1'b1;
          end_major   <= major_q;
          end_cfg_err <= cerr_q;
          end_bus_err <= berr_q;
          irq_done    <= major_q && ctl[CTL_IRQ_MAJ];
          irq_err     <= (cerr_q || berr_q) && ctl[CTL_IRQ_ERR];
          link_req    <= !cerr_q && !berr_q && ctl[CTL_LINK];
          link_ch     <= ctl[CTL_LCH_LSB +: CH_W];
          sg_req      <= major_q && ctl[CTL_SG];
          state       <= S_IDLE;
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  logic svc_req_q;
  always_ff @(posedge clk) begin
    if (rst || (state == S_IDLE && start)) svc_req_q <= 1'b0;
    else if (mem_req) svc_req_q <= 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size))); // R10
  AST_CFG_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (end_pulse && end_cfg_err) |-> !svc_req_q); // R2
  AST_DESC_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(desc_rd && desc_we)); // R5
  AST_NO_REQ_WHILE_LOAD: assert property (@(posedge clk) disable iff (rst)
    desc_rd |-> !mem_req); // R1
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (desc_we && desc_addr[2:0] == 3'd5) |-> (desc_wdata[IT_W-1:0] != '0)); // R6
  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
    end_pulse |-> ($onehot0({end_cfg_err, end_bus_err}) && !(end_major && (end_cfg_err || end_bus_err)))); // R7
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    (irq_done || irq_err || sg_req || link_req) |-> end_pulse); // R9
endmodule

// File: tb/sim_dxe_engine.sv
`timescale 1ns/1ps
module sim_dxe_engine;
  localparam int CH_NUM = 16;
  localparam int CH_W   = 4;
  localparam int DA_W   = CH_W + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            start = 1'b0;
  logic [CH_W-1:0] start_ch = '0;
  logic            desc_rd, desc_we;
  logic [DA_W-1:0] desc_addr;
  logic [31:0]     desc_wdata;
  logic [31:0]     desc_rdata = '0;
  logic            mem_req, mem_we;
  logic [31:0]     mem_addr, mem_wdata;
  logic [1:0]      mem_size;
  logic            mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0]     mem_rdata = '0;
  logic            busy, end_pulse, end_major, end_cfg_err, end_bus_err;
  logic            irq_done, irq_err, link_req, sg_req;
  logic [CH_W-1:0] link_ch;

  dxe_engine #(.CH_NUM(CH_NUM), .IT_W(16)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_ch(start_ch),
    .desc_rd(desc_rd), .desc_we(desc_we), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .end_pulse(end_pulse), .end_major(end_major),
    .end_cfg_err(end_cfg_err), .end_bus_err(end_bus_err),
    .irq_done(irq_done), .irq_err(irq_err), .link_req(link_req),
    .link_ch(link_ch), .sg_req(sg_req)
  );

  logic [31:0] dmem [0:CH_NUM*8-1];
  logic [7:0]  bmem [0:1023];
  int drd_cnt = 0, acc_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  int first_drd = 0, svc_first = 0, err_at = 0, wait_left = 0;
  int total = 0, bad = 0;

  // descriptor store: one-clock read latency
  always @(posedge clk) begin
    if (desc_rd) begin
      desc_rdata <= dmem[desc_addr];
      drd_cnt = drd_cnt + 1;
    end
    if (desc_we) dmem[desc_addr] = desc_wdata;
  end

  // memory responder with random wait states
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (!rst && mem_req && !mem_ack && !mem_err) begin
      if (wait_left > 0) wait_left = wait_left - 1;
      else begin
        acc_cnt = acc_cnt + 1;
        if (acc_cnt == svc_first) first_drd = drd_cnt;
        if (err_at != 0 && acc_cnt == err_at) mem_err <= 1'b1;
        else begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            wr_cnt = wr_cnt + 1;
            for (int k = 0; k < (1 << mem_size); k++)
              bmem[(mem_addr + k) & 1023] = mem_wdata[8*k +: 8];
          end else begin
            logic [31:0] r;
            rd_cnt = rd_cnt + 1;
            r = '0;
            for (int k = 0; k < (1 << mem_size); k++)
              r[8*k +: 8] = bmem[(mem_addr + k) & 1023];
            mem_rdata <= r;
          end
        end
        wait_left = $urandom_range(0, 2);
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  int n_acc, n_rd, n_wr, n_drd;
  logic c_major, c_cfg, c_bus, c_irqd, c_irqe, c_link, c_sg;
  logic [CH_W-1:0] c_lch;

  task automatic svc(input int ch);
    int a0, r0, w0, d0, t;
    a0 = acc_cnt; r0 = rd_cnt; w0 = wr_cnt; d0 = drd_cnt;
    svc_first = acc_cnt + 1;
    @(negedge clk); start = 1'b1; start_ch = CH_W'(ch);
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!end_pulse && t < 3000) begin @(negedge clk); t++; end
    chk("R1 service ended", longint'(end_pulse), 1);
    c_major = end_major; c_cfg = end_cfg_err; c_bus = end_bus_err;
    c_irqd = irq_done; c_irqe = irq_err; c_link = link_req; c_sg = sg_req; c_lch = link_ch;
    n_acc = acc_cnt - a0; n_rd = rd_cnt - r0; n_wr = wr_cnt - w0;
    n_drd = (n_acc > 0) ? first_drd - d0 : 8;
  endtask

  task automatic put_desc(input int ch, input int sa, input int da, input int nb,
                          input int so, input int dof, input int ss, input int ds,
                          input int ci, input int bi, input logic [31:0] ctl);
    dmem[ch*8+0] = sa;
    dmem[ch*8+1] = da;
    dmem[ch*8+2] = nb;
    dmem[ch*8+3] = {so[15:0], dof[15:0]};
    dmem[ch*8+4] = {28'd0, ds[1:0], ss[1:0]};
    dmem[ch*8+5] = {bi[15:0], ci[15:0]};
    dmem[ch*8+6] = ctl;
    dmem[ch*8+7] = 32'h0;
  endtask

  // good-descriptor service checked against a byte-stream model
  task automatic run_good(input int ch, input int sa, input int da, input int nb,
                          input int so, input int dof, input int ss, input int ds,
                          input int ci, input int bi, input logic [31:0] ctl);
    logic [7:0] strm [0:15];
    logic [7:0] expm [0:1023];
    int sb, db, nr, nw, bad_b, ncit;
    logic maj;
    sb = 1 << ss; db = 1 << ds; nr = nb / sb; nw = nb / db;
    for (int i = 0; i < 1024; i++) expm[i] = bmem[i];
    for (int i = 0; i < nr; i++)
      for (int k = 0; k < sb; k++) strm[i*sb+k] = bmem[(sa + i*so + k) & 1023];
    for (int j = 0; j < nw; j++)
      for (int k = 0; k < db; k++) expm[(da + j*dof + k) & 1023] = strm[j*db+k];
    maj = (ci == 1);
    ncit = maj ? bi : ci - 1;
    put_desc(ch, sa, da, nb, so, dof, ss, ds, ci, bi, ctl);
    svc(ch);
    bad_b = 0;
    for (int i = 0; i < 1024; i++) if (bmem[i] !== expm[i]) bad_b++;
    chk("R3 memory image mismatches", bad_b, 0);
    chk("R3 read count", n_rd, nr);
    chk("R3 write count", n_wr, nw);
    chk("R1 descriptor reads before first access", n_drd, 8);
    chk("R4 R5 source write-back", dmem[ch*8+0], 32'(sa + nr*so));
    chk("R4 R5 dest write-back", dmem[ch*8+1], 32'(da + nw*dof));
    chk("R5 R6 count word", dmem[ch*8+5], {bi[15:0], 16'(ncit)});
    chk("R6 status word", dmem[ch*8+6], (ctl & ~32'hC) | (32'(maj) << 2));
    chk("R6 end_major", c_major, maj);
    chk("R6 irq_done", c_irqd, maj & ctl[0]);
    chk("R9 link_req", c_link, ctl[4]);
    if (ctl[4]) chk("R9 link_ch", c_lch, ctl[11:8]);
    chk("R9 sg_req", c_sg, maj & ctl[5]);
    chk("R7 no error flags", {c_cfg, c_bus, c_irqe}, 0);
  endtask

  task automatic run_cfg_bad(input int ch, input int sa, input int da, input int nb,
                             input int ss, input int ds, input int ci, input logic [31:0] ctl);
    put_desc(ch, sa, da, nb, 1 << ss, 1 << ds, ss, ds, ci, 2, ctl);
    svc(ch);
    chk("R2 no bus access", n_acc, 0);
    chk("R2 end_cfg_err", c_cfg, 1);
    chk("R2 irq_err", c_irqe, ctl[1]);
    chk("R2 status err bit", dmem[ch*8+6], ctl | 32'h8);
    chk("R2 source word untouched", dmem[ch*8+0], 32'(sa));
    chk("R2 no link on error", c_link, 0);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd = wd + 1;
    if (wd == 190000) begin
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp=<190000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) bmem[i] = 8'($urandom);
    for (int i = 0; i < CH_NUM*8; i++) dmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R11 busy at reset", busy, 0);
    chk("R11 req at reset", {mem_req, desc_rd, desc_we}, 0);
    chk("R11 end flags at reset", {end_pulse, end_major, end_cfg_err, end_bus_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after reset", {busy, mem_req, desc_rd}, 0);

    // R3: byte reads into word writes, 16 bytes
    run_good(3, 32'h080, 32'h280, 16, 1, 4, 0, 2, 3, 3, 32'h0000_0510);
    chk("R3 sixteen reads", n_rd, 16);
    chk("R3 four writes", n_wr, 4);
    // R4: word reads into byte writes, backwards strides
    run_good(4, 32'h090, 32'h290, 8, -4, -1, 2, 0, 2, 2, 32'h0);

    // R6: two-step major loop
    run_good(7, 32'h080, 32'h280, 4, 2, 2, 1, 1, 2, 2, 32'h0000_0021);
    chk("R6 first pass not major", c_major, 0);
    begin
      int d0;
      d0 = dmem[7*8+0];
      run_good(7, d0, dmem[7*8+1], 4, 2, 2, 1, 1, 1, 2, 32'h0000_0021);
      chk("R6 second pass major", c_major, 1);
      chk("R6 reload to start count", dmem[7*8+5][15:0], 2);
    end

    // R2: configuration errors
    run_cfg_bad(1, 32'h080, 32'h280, 4, 3, 0, 1, 32'h2);
    run_cfg_bad(1, 32'h080, 32'h280, 6, 0, 2, 1, 32'h2);
    run_cfg_bad(2, 32'h081, 32'h280, 8, 1, 1, 1, 32'h0);
    run_cfg_bad(2, 32'h080, 32'h282, 8, 0, 2, 1, 32'h12);
    run_cfg_bad(5, 32'h080, 32'h280, 4, 0, 0, 0, 32'h2);
    run_cfg_bad(5, 32'h080, 32'h280, 0, 0, 0, 1, 32'h2);

    // R7: bus error on the second access
    put_desc(6, 32'h080, 32'h280, 8, 1, 1, 0, 0, 1, 1, 32'h0000_0012);
    err_at = acc_cnt + 2;
    svc(6);
    err_at = 0;
    chk("R7 two accesses", n_acc, 2);
    chk("R7 end_bus_err", c_bus, 1);
    chk("R7 irq_err", c_irqe, 1);
    chk("R7 status err bit", dmem[6*8+6], 32'h0000_001A);
    chk("R7 source not written back", dmem[6*8+0], 32'h080);
    chk("R7 no link", c_link, 0);
    begin
      int a1;
      a1 = acc_cnt;
      repeat (20) @(negedge clk);
      chk("R7 no access after abort", acc_cnt - a1, 0);
    end

    // R8: start while busy is ignored
    put_desc(9, 32'h080, 32'h280, 16, 1, 1, 0, 0, 3, 3, 32'h0);
    put_desc(10, 32'h0A0, 32'h2A0, 4, 1, 1, 0, 0, 3, 3, 32'h0000_ABC0);
    @(negedge clk); start = 1'b1; start_ch = CH_W'(9);
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; start_ch = CH_W'(10);
    @(negedge clk); start = 1'b0;
    begin
      int t;
      t = 0;
      while (!end_pulse && t < 3000) begin @(negedge clk); t++; end
      repeat (30) @(negedge clk);
      chk("R8 engine idle after one service", busy, 0);
      chk("R8 second channel untouched", dmem[10*8+6], 32'h0000_ABC0);
      chk("R8 second channel count untouched", dmem[10*8+5], 32'h0003_0003);
    end

    // random services
    for (int n = 0; n < 40; n++) begin
      int ss, ds, sb, db, big, nb, so, dof, ci, bi, ch;
      logic [31:0] ctl;
      ss = $urandom_range(0, 2); ds = $urandom_range(0, 2);
      sb = 1 << ss; db = 1 << ds; big = (sb > db) ? sb : db;
      nb = big * $urandom_range(1, 16 / big);
      case ($urandom_range(0, 2)) 0: so = sb; 1: so = -sb; default: so = 2*sb; endcase
      case ($urandom_range(0, 2)) 0: dof = db; 1: dof = -db; default: dof = 2*db; endcase
      ci = $urandom_range(1, 3); bi = $urandom_range(ci, 3);
      ch = $urandom_range(0, CH_NUM-1);
      ctl = {16'd0, 4'd0, 4'($urandom), 2'b00, 6'($urandom)};
      run_good(ch, 32'h080, 32'h280, nb, so, dof, ss, ds, ci, bi, ctl);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule